// File: doc/BRIEF.md
# Machine/User Privilege Trap Controller

This block holds the privilege level of a single-hart core that implements only two modes, Machine and User, together with the machine trap registers: the interrupt-enable stack in the status word, the exception PC, the cause, the trap value and the vector base. When the pipeline raises an exception or interrupt, the block pushes the one-level privilege stack, records the cause, the PC and the trap value, moves the hart to Machine mode and supplies the handler address in the same cycle. When the pipeline signals a trap return, it pops the stack, drops to the saved mode and supplies the saved PC.

The vector register works only in vectored form. Interrupts land at base plus four times their cause code, exceptions land at the base itself, and the base is held on a 256-byte boundary. A small CSR read/write port reaches the five registers so that software and tests can set them up and observe them. Instruction decode, memory protection checks, interrupt selection and every other CSR live outside this block.

Top module: `mu_trap_ctrl`

## Requirements
- R1: When `trap_req_i` is high at a clock edge, after that edge the saved-mode field holds the mode that was current, the previous-enable bit holds the old interrupt enable, the interrupt enable is 0 and `priv_o` is 2'b11.
- R2: A trap writes the cause register with bit XLEN-1 equal to `trap_irq_i` and bits CODE_W-1:0 equal to `trap_code_i`; all other cause bits read 0, also after a CSR write to address 0x342.
- R3: A trap writes `trap_pc_i` unchanged into the exception PC register (address 0x341); the requester supplies the faulting PC for exceptions and the next PC for interrupts.
- R4: A trap writes `trap_val_i` into the trap value register (address 0x343), except that interrupts and the exception codes 3 (breakpoint), 8 (environment call from User) and 11 (environment call from Machine) write zero.
- R5: In the cycle of a trap request, `redirect_valid_o` is 1 and `redirect_pc_o` equals the vector base for an exception and the vector base plus 4 × code for an interrupt.
- R6: When `mret_i` is high without a trap, `redirect_pc_o` equals the exception PC in that cycle; after the edge the mode equals the saved mode, the interrupt enable equals the old previous-enable bit, the previous-enable bit is 1 and the saved mode is User.
- R7: `priv_o` is 2'b00 for User and 2'b11 for Machine and never another value; a status write whose bits 12:11 are 2'b01 or 2'b10 leaves the saved-mode field unchanged.
- R8: The status register (address 0x300) holds the interrupt enable in bit 3, the previous enable in bit 7 and the saved mode in bits 12:11; all other bits read 0.
- R9: A write to the vector register (address 0x305) keeps bits XLEN-1:8; bits 7:0 always read 0x01 (vectored mode, 256-byte aligned base).
- R10: When a trap request and `mret_i` arrive in the same cycle, the trap is taken and the return has no effect.
- R11: A CSR write in a cycle with a trap or return request is dropped; a read of any address other than the five listed returns 0.
- R12: After reset the mode is Machine, both enable bits are 0, the saved mode is User, the vector register reads RESET_BASE with bits 7:0 equal to 0x01, and the PC, cause and value registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req_i | input | 1 | Take a trap this cycle |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | CODE_W | Cause code of the trap |
| trap_val_i | input | XLEN | Faulting address or instruction bits |
| trap_pc_i | input | XLEN | PC to save in the exception PC register |
| mret_i | input | 1 | Trap return strobe |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational on address) |
| redirect_valid_o | output | 1 | A new PC must be fetched |
| redirect_pc_o | output | XLEN | Target PC of the redirect |
| priv_o | output | 2 | Current privilege encoding |

## Verification
The bench builds the block with XLEN = 32 and CODE_W = 6, so all 64 cause codes of both the interrupt and the exception kind can be swept, each from a User and a Machine starting point, together with every combination of the two enable bits. With a 6-bit code the largest vectored offset is 252 bytes, which lets the sweep confirm that no interrupt target leaves the 256-byte vector window and that exactly the three zero-value exception codes suppress the trap value.

// File: rtl/mu_trap_pkg.sv
package mu_trap_pkg;

    // CSR addresses decoded by the block
    localparam logic [11:0] ADDR_STATUS = 12'h300;
    localparam logic [11:0] ADDR_TVEC   = 12'h305;
    localparam logic [11:0] ADDR_EPC    = 12'h341;
    localparam logic [11:0] ADDR_CAUSE  = 12'h342;
    localparam logic [11:0] ADDR_TVAL   = 12'h343;

    // Status word bit positions
    localparam int BIT_IE   = 3;
    localparam int BIT_PIE  = 7;
    localparam int BIT_PPLO = 11;
    localparam int BIT_PPHI = 12;

    // Exception codes that leave the trap value at zero
    localparam int CODE_BREAK   = 3;
    localparam int CODE_CALL_LO = 8;
    localparam int CODE_CALL_HI = 11;

    // Vector alignment
    localparam int VEC_ALIGN_BITS = 8;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_RET  = 2'd2
    } ev_e;

    // Privilege stack; modes kept as one bit (1 = Machine)
    typedef struct packed {
        logic priv_m;
        logic ie;
        logic pie;
        logic pp_m;
    } stack_t;

endpackage

// File: rtl/mu_event_sel.sv
module mu_event_sel
    import mu_trap_pkg::*;
(
    input  logic trap_req_i,
    input  logic mret_i,
    input  logic csr_we_i,
    output ev_e  ev_o,
    output logic wr_ok_o
);
    always_comb begin
        if (trap_req_i) begin
            ev_o = EV_TRAP;
        end else if (mret_i) begin
            ev_o = EV_RET;
        end else begin
            ev_o = EV_NONE;
        end
        wr_ok_o = csr_we_i && (ev_o == EV_NONE);
    end
endmodule

// File: rtl/mu_stack_unit.sv
module mu_stack_unit
    import mu_trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ev_e        ev_i,
    input  logic       wr_i,
    input  logic       wr_ie_i,
    input  logic       wr_pie_i,
    input  logic [1:0] wr_pp_i,
    output stack_t     stack_o
);
    stack_t stack_d, stack_q;

    always_comb begin
        stack_d = stack_q;
        unique case (ev_i)
            EV_TRAP: begin
                stack_d.pp_m   = stack_q.priv_m;
                stack_d.pie    = stack_q.ie;
                stack_d.ie     = 1'b0;
                stack_d.priv_m = 1'b1;
            end
            EV_RET: begin
                stack_d.priv_m = stack_q.pp_m;
                stack_d.ie     = stack_q.pie;
                stack_d.pie    = 1'b1;
                stack_d.pp_m   = 1'b0;
            end
            default: begin
                if (wr_i) begin
                    stack_d.ie  = wr_ie_i;
                    stack_d.pie = wr_pie_i;
                    if (wr_pp_i == 2'b11) begin
                        stack_d.pp_m = 1'b1;
                    end else if (wr_pp_i == 2'b00) begin
                        stack_d.pp_m = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stack_q <= '{priv_m: 1'b1, ie: 1'b0, pie: 1'b0, pp_m: 1'b0};
        end else begin
            stack_q <= stack_d;
        end
    end

    assign stack_o = stack_q;
endmodule

// File: rtl/mu_trap_regs.sv
module mu_trap_regs
    import mu_trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int CODE_W     = 6,
    parameter logic [XLEN-1:0] RESET_BASE = '0,
    localparam int BASE_W    = XLEN - VEC_ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_e               ev_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [XLEN-1:0]   trap_val_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic              wr_i,
    input  logic [11:0]       wr_addr_i,
    input  logic [XLEN-1:0]   wr_data_i,
    output logic [BASE_W-1:0] base_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              cause_irq_o,
    output logic [CODE_W-1:0] cause_code_o,
    output logic [XLEN-1:0]   tval_o
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [XLEN-1:0]   epc;
        logic              irq;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   tval;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  zero_val;

    always_comb begin
        zero_val = trap_irq_i
                || (int'(trap_code_i) == CODE_BREAK)
                || (int'(trap_code_i) == CODE_CALL_LO)
                || (int'(trap_code_i) == CODE_CALL_HI);

        regs_d = regs_q;
        if (ev_i == EV_TRAP) begin
            regs_d.epc  = trap_pc_i;
            regs_d.irq  = trap_irq_i;
            regs_d.code = trap_code_i;
            regs_d.tval = zero_val ? '0 : trap_val_i;
        end else if (wr_i) begin
            unique case (wr_addr_i)
                ADDR_TVEC:  regs_d.base = wr_data_i[XLEN-1:VEC_ALIGN_BITS];
                ADDR_EPC:   regs_d.epc  = wr_data_i;
                ADDR_CAUSE: begin
                    regs_d.irq  = wr_data_i[XLEN-1];
                    regs_d.code = wr_data_i[CODE_W-1:0];
                end
                ADDR_TVAL:  regs_d.tval = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.base <= RESET_BASE[XLEN-1:VEC_ALIGN_BITS];
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_o       = regs_q.base;
    assign epc_o        = regs_q.epc;
    assign cause_irq_o  = regs_q.irq;
    assign cause_code_o = regs_q.code;
    assign tval_o       = regs_q.tval;
endmodule

// File: rtl/mu_redirect.sv
module mu_redirect
    import mu_trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CODE_W  = 6,
    localparam int BASE_W = XLEN - VEC_ALIGN_BITS
) (
    input  ev_e               ev_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [XLEN-1:0]   epc_i,
    output logic              valid_o,
    output logic [XLEN-1:0]   pc_o
);
    logic [VEC_ALIGN_BITS-1:0] offset;

    always_comb begin
        offset = '0;
        if (trap_irq_i) begin
            offset = VEC_ALIGN_BITS'(trap_code_i) << 2;
        end
        valid_o = (ev_i != EV_NONE);
        unique case (ev_i)
            EV_TRAP: pc_o = {base_i, offset};
            EV_RET:  pc_o = epc_i;
            default: pc_o = '0;
        endcase
    end
endmodule

// File: rtl/mu_trap_ctrl.sv
module mu_trap_ctrl
    import mu_trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int CODE_W     = 6,
    parameter logic [XLEN-1:0] RESET_BASE = '0,
    localparam int BASE_W    = XLEN - VEC_ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [XLEN-1:0]   trap_val_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic              mret_i,
    input  logic              csr_we_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [1:0]        priv_o
);
    // Offsets of at most 4*(2^CODE_W - 1) must stay inside the aligned window
    if (CODE_W > VEC_ALIGN_BITS - 2) begin : g_bad_code_w
        initial $error("CODE_W too large for the vector window");
    end
    if (XLEN < 16) begin : g_bad_xlen
        initial $error("XLEN too small");
    end

    ev_e               ev;
    logic              wr_ok;
    stack_t            stk;
    logic              st_priv_m, st_ie, st_pie, st_pp_m;
    logic [BASE_W-1:0] base;
    logic [XLEN-1:0]   epc, tval;
    logic              cause_irq;
    logic [CODE_W-1:0] cause_code;

    mu_event_sel i_sel (
        .trap_req_i (trap_req_i),
        .mret_i     (mret_i),
        .csr_we_i   (csr_we_i),
        .ev_o       (ev),
        .wr_ok_o    (wr_ok)
    );

    mu_stack_unit i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .wr_i     (wr_ok && (csr_addr_i == ADDR_STATUS)),
        .wr_ie_i  (csr_wdata_i[BIT_IE]),
        .wr_pie_i (csr_wdata_i[BIT_PIE]),
        .wr_pp_i  (csr_wdata_i[BIT_PPHI:BIT_PPLO]),
        .stack_o  (stk)
    );

    assign st_priv_m = stk.priv_m;
    assign st_ie     = stk.ie;
    assign st_pie    = stk.pie;
    assign st_pp_m   = stk.pp_m;

    mu_trap_regs #(
        .XLEN       (XLEN),
        .CODE_W     (CODE_W),
        .RESET_BASE (RESET_BASE)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev),
        .trap_irq_i   (trap_irq_i),
        .trap_code_i  (trap_code_i),
        .trap_val_i   (trap_val_i),
        .trap_pc_i    (trap_pc_i),
        .wr_i         (wr_ok),
        .wr_addr_i    (csr_addr_i),
        .wr_data_i    (csr_wdata_i),
        .base_o       (base),
        .epc_o        (epc),
        .cause_irq_o  (cause_irq),
        .cause_code_o (cause_code),
        .tval_o       (tval)
    );

    mu_redirect #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) i_redir (
        .ev_i        (ev),
        .trap_irq_i  (trap_irq_i),
        .trap_code_i (trap_code_i),
        .base_i      (base),
        .epc_i       (epc),
        .valid_o     (redirect_valid_o),
        .pc_o        (redirect_pc_o)
    );

    always_comb begin
        csr_rdata_o = '0;
        unique case (csr_addr_i)
            ADDR_STATUS: begin
                csr_rdata_o[BIT_IE]             = st_ie;
                csr_rdata_o[BIT_PIE]            = st_pie;
                csr_rdata_o[BIT_PPHI:BIT_PPLO]  = {st_pp_m, st_pp_m};
            end
            ADDR_TVEC:  csr_rdata_o = {base, VEC_ALIGN_BITS'(1)};
            ADDR_EPC:   csr_rdata_o = epc;
            ADDR_CAUSE: begin
                csr_rdata_o[XLEN-1]     = cause_irq;
                csr_rdata_o[CODE_W-1:0] = cause_code;
            end
            ADDR_TVAL:  csr_rdata_o = tval;
            default: ;
        endcase
        priv_o = {st_priv_m, st_priv_m};
    end
endmodule

// File: rtl/mu_trap_ctrl_chk.sv
module mu_trap_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req_i,
    input logic            trap_irq_i,
    input logic            mret_i,
    input logic            redirect_valid_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic [1:0]      priv_o,
    input logic            st_priv_m,
    input logic            st_ie,
    input logic            st_pie,
    input logic            st_pp_m
);
    assert_trap_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_i |=> (priv_o == 2'b11) && !st_ie);

    assert_trap_stack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_i |=> (st_pie == $past(st_ie)) && (st_pp_m == $past(st_priv_m)));

    assert_exc_base_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && !trap_irq_i) |-> redirect_valid_o && (redirect_pc_o[7:0] == 8'h00));

    assert_irq_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && trap_irq_i) |-> redirect_valid_o && (redirect_pc_o[1:0] == 2'b00));

    assert_ret_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && !trap_req_i) |=> (st_priv_m == $past(st_pp_m)) && (st_ie == $past(st_pie))
                                    && st_pie && !st_pp_m);

    assert_priv_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_o == 2'b00) || (priv_o == 2'b11));

    assert_trap_beats_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i && mret_i) |=> st_priv_m && !st_ie && (st_pie == $past(st_ie)));

    assert_quiet_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req_i && !mret_i) |=> $stable(st_priv_m));
endmodule

bind mu_trap_ctrl mu_trap_ctrl_chk #(.XLEN(XLEN)) i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .trap_req_i       (trap_req_i),
    .trap_irq_i       (trap_irq_i),
    .mret_i           (mret_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .priv_o           (priv_o),
    .st_priv_m        (st_priv_m),
    .st_ie            (st_ie),
    .st_pie           (st_pie),
    .st_pp_m          (st_pp_m)
);

// File: tb/test_mu_trap_ctrl.sv
module test_mu_trap_ctrl;
    localparam int XLEN = 32;
    localparam int CW   = 6;

    localparam logic [11:0] A_ST = 12'h300;
    localparam logic [11:0] A_TV = 12'h305;
    localparam logic [11:0] A_EP = 12'h341;
    localparam logic [11:0] A_CA = 12'h342;
    localparam logic [11:0] A_VA = 12'h343;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0, trap_irq = 1'b0, mret = 1'b0, we = 1'b0;
    logic [CW-1:0]   code = '0;
    logic [XLEN-1:0] tval_in = '0, pc_in = '0, wdata = '0;
    logic [11:0]     addr = 12'h000;
    logic [XLEN-1:0] rdata, rpc;
    logic            rvalid;
    logic [1:0]      priv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    bit              m_priv, m_ie, m_pie, m_pp;
    logic [XLEN-1:0] m_tvec, m_epc, m_cause, m_tval;

    always #2 clk = ~clk;

    mu_trap_ctrl #(.XLEN(XLEN), .CODE_W(CW)) i_mu_trap_ctrl (
        .clk(clk), .rst_n(rst_n),
        .trap_req_i(trap_req), .trap_irq_i(trap_irq), .trap_code_i(code),
        .trap_val_i(tval_in), .trap_pc_i(pc_in), .mret_i(mret),
        .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_rdata_o(rdata), .redirect_valid_o(rvalid), .redirect_pc_o(rpc),
        .priv_o(priv)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] st_word();
        logic [XLEN-1:0] w = '0;
        w[3] = m_ie; w[7] = m_pie; w[12:11] = {m_pp, m_pp};
        return w;
    endfunction

    task automatic rd(input string req, input logic [11:0] a, input logic [XLEN-1:0] exp);
        @(negedge clk);
        addr = a;
        #0.5;
        chk(req, rdata, exp);
    endtask

    task automatic check_all(input string req);
        rd({req, " status"}, A_ST, st_word());
        rd({req, " vector"}, A_TV, m_tvec);
        rd({req, " epc"},    A_EP, m_epc);
        rd({req, " cause"},  A_CA, m_cause);
        rd({req, " tval"},   A_VA, m_tval);
        chk({req, " priv"}, XLEN'(priv), m_priv ? 32'd3 : 32'd0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        case (a)
            A_ST: begin
                m_ie = d[3]; m_pie = d[7];
                if (d[12:11] == 2'b11) m_pp = 1'b1;
                else if (d[12:11] == 2'b00) m_pp = 1'b0;
            end
            A_TV: m_tvec = {d[XLEN-1:8], 8'h01};
            A_EP: m_epc = d;
            A_CA: m_cause = {d[XLEN-1], {(XLEN-1-CW){1'b0}}, d[CW-1:0]};
            A_VA: m_tval = d;
            default: ;
        endcase
    endtask

    task automatic do_ret(input string req);
        @(negedge clk);
        mret = 1'b1;
        #0.5;
        chk({req, " ret valid"}, XLEN'(rvalid), 32'd1);
        chk({req, " ret pc"}, rpc, m_epc);
        @(negedge clk);
        mret = 1'b0;
        m_priv = m_pp; m_ie = m_pie; m_pie = 1'b1; m_pp = 1'b0;
    endtask

    task automatic do_trap(input string req, input bit irq, input logic [CW-1:0] c,
                           input logic [XLEN-1:0] v, input logic [XLEN-1:0] p,
                           input bit with_ret, input bit with_wr);
        logic [XLEN-1:0] exp_pc;
        @(negedge clk);
        trap_req = 1'b1; trap_irq = irq; code = c; tval_in = v; pc_in = p;
        mret = with_ret;
        if (with_wr) begin
            we = 1'b1; addr = A_VA; wdata = 32'hDEAD_BEEF;
        end
        exp_pc = irq ? {m_tvec[XLEN-1:8], 8'(c) << 2} : {m_tvec[XLEN-1:8], 8'h00};
        #0.5;
        chk({req, " trap valid"}, XLEN'(rvalid), 32'd1);
        chk({req, " trap pc"}, rpc, exp_pc);
        @(negedge clk);
        trap_req = 1'b0; mret = 1'b0; we = 1'b0;
        m_pp = m_priv; m_pie = m_ie; m_ie = 1'b0; m_priv = 1'b1;
        m_epc = p;
        m_cause = {irq, {(XLEN-1-CW){1'b0}}, c};
        m_tval = (irq || c == 3 || c == 8 || c == 11) ? '0 : v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_priv = 1; m_ie = 0; m_pie = 0; m_pp = 0;
        m_tvec = 32'h0000_0001; m_epc = '0; m_cause = '0; m_tval = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check_all("R12");
        @(negedge clk);
        #0.5;
        chk("R12 idle valid", XLEN'(rvalid), 32'd0);

        // R9 vector alignment and mode bits
        wr(A_TV, 32'h1234_56FE);
        rd("R9 vector", A_TV, 32'h1234_5601);

        // R11 unmapped read
        wr(12'h344, 32'hFFFF_FFFF);
        rd("R11 unmapped", 12'h344, 32'h0);

        // R7 reserved saved-mode encodings ignored
        wr(A_ST, 32'h0000_1800);
        wr(A_ST, 32'h0000_0800);
        rd("R7 pp 01 ignored", A_ST, st_word());
        wr(A_ST, 32'h0000_1000);
        rd("R7 pp 10 ignored", A_ST, st_word());
        // R8 other status bits read zero
        wr(A_ST, 32'hFFFF_E777);
        rd("R8 status fields", A_ST, st_word());

        // R2 cause write masking
        wr(A_CA, 32'hFFFF_FFFF);
        rd("R2 cause write", A_CA, 32'h8000_003F);

        // R1..R6 sweep: every code, both kinds, both start modes, enable patterns
        for (int irq = 0; irq < 2; irq++) begin
            for (int c = 0; c < 64; c++) begin
                for (int su = 0; su < 2; su++) begin
                    logic [XLEN-1:0] sw;
                    sw = '0;
                    sw[12:11] = su ? 2'b00 : 2'b11;
                    sw[3] = c[0];
                    sw[7] = c[1] ^ su[0];
                    wr(A_ST, sw);
                    do_ret("R6");
                    chk("R6 mode after ret", XLEN'(priv), su ? 32'd0 : 32'd3);
                    do_trap("R5", irq[0], CW'(c), 32'hA500_0000 | (c << 4) | irq,
                            32'h4000_0000 + c * 4 + irq * 32'h100, 1'b0, 1'b0);
                    check_all("R1-sweep R2 R3 R4");
                end
            end
        end

        // R10 trap and return together: trap wins
        wr(A_ST, 32'h0000_0088);
        do_ret("R10 setup");
        do_trap("R10", 1'b0, 6'd2, 32'h0000_1013, 32'h8000_0040, 1'b1, 1'b0);
        check_all("R10");

        // R11 CSR write dropped during trap
        do_trap("R11", 1'b0, 6'd5, 32'h0BAD_F00D, 32'h8000_0080, 1'b0, 1'b1);
        rd("R11 write during trap", A_VA, 32'h0BAD_F00D);

        // R11 CSR write dropped during return
        wr(A_ST, 32'h0000_0080);
        @(negedge clk);
        mret = 1'b1; we = 1'b1; addr = A_ST; wdata = 32'h0000_1808;
        @(negedge clk);
        mret = 1'b0; we = 1'b0;
        m_priv = m_pp; m_ie = m_pie; m_pie = 1'b1; m_pp = 1'b0;
        check_all("R11 write during ret");

        // R4 ecall from User gives zero value
        do_trap("R4", 1'b0, 6'd8, 32'hFFFF_FFFF, 32'h0000_2000, 1'b0, 1'b0);
        rd("R4 ecall zero", A_VA, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule